// File: doc/BRIEF.md
# ISA Bus Cycle Command Generator

This block runs cycles on an ISA-style expansion bus for three internal requesters: the host, a DMA engine and a refresh engine. A request is a single-cycle pulse that carries an address, a read/write flag, a memory/IO flag, a 16-bit width flag and a source code. The block latches the request and plays out a fixed phase sequence: an address phase, a gap, a command phase that the bus can stretch, and an end phase that reports completion. It drives the address lanes, the byte-high enable, the four command strobes, the refresh strobe and the qualified low-megabyte memory strobes.

When an add-on card takes the bus, the block stops driving. Each pin group gets its own output enable, and these enables drop. In that mode the block can also answer with a ready line for accesses that hit internal resources, holding that line low for a fixed number of cycles. A separate latch turns an active channel-check input into a sticky NMI request, gated by an enable bit.

The data-path transceivers, DMA channel programming and host-side decoding live outside this block.

Top module: `isa_cycle_gen`

## Requirements
- R1: While `ext_master` is 1, `la_oe`, `sa_oe` and `cmd_oe` are 0. At all other times, including idle, they are 1.
- R2: A request pulse is taken only when the block is idle and `ext_master` is 0; otherwise it is dropped. A taken request gives one address cycle, one gap cycle, at least 3 command cycles and one end cycle. `busy` is 1 from the address cycle through the end cycle, and `done` is 1 only in the end cycle.
- R3: Source code `req_src` 0 (or 3) means host, 1 means DMA and 2 means refresh. In the command phase of a non-refresh cycle, exactly one strobe goes low: `memr_n` (memory read), `memw_n` (memory write), `ior_n` (IO read, `req_io`=1) or `iow_n` (IO write). A refresh cycle lowers only `memr_n` in its command phase, and it holds `ref_n` low from the address cycle through the end cycle.
- R4: `iochrdy_in` is sampled from the third command cycle onward. Each cycle in which it is 0 there adds one more command cycle.
- R5: `smemw_n` follows `memw_n` only when address bits [23:20] are all zero. `smemr_n` follows `memr_n` when those bits are zero or the cycle is a refresh. Otherwise both stay high.
- R6: `ale` is 0 after reset and while idle without an external owner. In a host cycle it is 1 only in the address cycle. In DMA and refresh cycles it is 1 from the address cycle through the end cycle. It is 1 whenever `ext_master` is 1.
- R7: `bhe_n` is 0 from the address cycle through the end cycle when `req_wide` is 1 or address bit 0 is 1, except in refresh cycles. It is 1 otherwise.
- R8: `aen` equals `dma_owner` at all times.
- R9: `done_wide` is 1 in the end cycle when `mcs16_n_in` was 0 in the last command cycle of a memory, non-refresh cycle. It is 0 for IO and refresh cycles.
- R10: `iochrdy_oe` equals `ext_master AND ext_hit`. If `ext_master`, `ext_hit` and `ext_cmd` are all 1 at a clock edge and `ext_cmd` was 0 at the edge before, `iochrdy_out` is 0 for the next 4 cycles and 1 afterwards. The countdown clears while `ext_master` is 0.
- R11: `nmi_req` is set one cycle after a clock edge that sees `iochck_n_in`=0 with `nmi_en`=1. It stays set until an edge with `nmi_clr`=1 and no new set condition. Setting wins over clearing.
- R12: `la_out` shows address bits [23:17] and `sa_out` shows bits [19:0] of the last accepted request, from its address cycle until the next request is taken. Both are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock |
| rst_n | input | 1 | active-low asynchronous reset |
| req_valid | input | 1 | request pulse |
| req_addr | input | 24 | request address |
| req_write | input | 1 | 1 = write |
| req_io | input | 1 | 1 = IO space |
| req_wide | input | 1 | 1 = 16-bit transfer |
| req_src | input | 2 | requester: 0 host, 1 DMA, 2 refresh |
| ext_master | input | 1 | add-on card owns the bus |
| dma_owner | input | 1 | DMA controller owns the bus |
| ext_hit | input | 1 | external cycle targets an internal resource |
| ext_cmd | input | 1 | external master command strobe active |
| iochrdy_in | input | 1 | sampled channel ready |
| mcs16_n_in | input | 1 | sampled 16-bit memory select, active low |
| iochck_n_in | input | 1 | sampled channel check, active low |
| nmi_en | input | 1 | NMI enable bit |
| nmi_clr | input | 1 | NMI clear strobe |
| la_out | output | 7 | upper address lanes |
| la_oe | output | 1 | enable for la_out |
| sa_out | output | 20 | system address lanes |
| sa_oe | output | 1 | enable for sa_out and bhe_n |
| bhe_n | output | 1 | byte-high enable, active low |
| ale | output | 1 | address latch enable |
| aen | output | 1 | DMA address enable |
| memr_n | output | 1 | memory read strobe |
| memw_n | output | 1 | memory write strobe |
| smemr_n | output | 1 | low-megabyte memory read |
| smemw_n | output | 1 | low-megabyte memory write |
| ior_n | output | 1 | IO read strobe |
| iow_n | output | 1 | IO write strobe |
| ref_n | output | 1 | refresh strobe |
| cmd_oe | output | 1 | enable for command and refresh strobes |
| iochrdy_out | output | 1 | ready driven in external-master mode |
| iochrdy_oe | output | 1 | enable for iochrdy_out |
| busy | output | 1 | cycle in progress |
| done | output | 1 | end-cycle pulse |
| done_wide | output | 1 | target answered as 16-bit memory |
| nmi_req | output | 1 | sticky NMI request |

## Verification
The cycle engine is driven with a mix of cycles so that each strobe and qualifier can be told apart:
- Memory reads and writes sit on both sides of the 1 MByte line, which separates the qualified strobes from the plain ones.
- Odd and even, narrow and wide transfers show the byte-high rule at work.
- IO reads and writes, a refresh at a high address and a DMA read each select a different strobe and a different ALE shape.
- Ready held low for several cycles measures the stretch of the command phase.
- The 16-bit select is pulled low in a memory cycle and in an IO cycle, which shows where it is honoured and where it is ignored.
- Requests arrive while an external master owns the bus and while the block is busy, and the bench checks that they are dropped.
- Channel-check pulses arrive with the enable off and on, and against a clear, to show gating, stickiness and priority.

// File: rtl/isa_cycle_pkg.sv
package isa_cycle_pkg;

   typedef enum logic [1:0] {
      SRC_HOST    = 2'd0,
      SRC_DMA     = 2'd1,
      SRC_REFRESH = 2'd2
   } isa_src_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ADDR = 3'd1,
      ST_GAP  = 3'd2,
      ST_CMD  = 3'd3,
      ST_END  = 3'd4
   } isa_state_e;

   typedef struct packed {
      logic     write;
      logic     io;
      logic     wide;
      isa_src_e src;
   } isa_kind_t;

endpackage

// File: rtl/isa_cycle_fsm.sv
module isa_cycle_fsm
   import isa_cycle_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int MIN_CMD = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  isa_kind_t         req_kind,
   input  logic              ext_master,
   input  logic              iochrdy_in,
   input  logic              mcs16_n_in,
   output isa_state_e        state,
   output logic [ADDR_W-1:0] addr_q,
   output isa_kind_t         kind_q,
   output logic              done_wide
);

   localparam int CNT_W = $clog2(MIN_CMD + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_CMD - 1);

   if (MIN_CMD < 1) begin : g_bad_min
      $error("isa_cycle_fsm: MIN_CMD must be at least 1");
   end

   logic [CNT_W-1:0] cnt;
   logic             wide_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         addr_q <= '0;
         kind_q <= '0;
         cnt    <= '0;
         wide_q <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_valid && !ext_master) begin
                  addr_q <= req_addr;
                  kind_q <= req_kind;
                  state  <= ST_ADDR;
               end
            end
            ST_ADDR: state <= ST_GAP;
            ST_GAP: begin
               state <= ST_CMD;
               cnt   <= '0;
            end
            ST_CMD: begin
               if (cnt == CNT_LAST) begin
                  if (iochrdy_in) begin
                     state  <= ST_END;
                     wide_q <= !mcs16_n_in && !kind_q.io &&
                               (kind_q.src != SRC_REFRESH);
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_END:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign done_wide = (state == ST_END) && wide_q;

   // R4: a low ready in the command phase keeps the command phase
   a_r4_hold_while_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CMD && !iochrdy_in) |=> (state == ST_CMD));

   // R2: the address cycle is always followed by the gap cycle
   a_r2_gap_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR) |=> (state == ST_GAP));

endmodule

// File: rtl/isa_strobe_gen.sv
module isa_strobe_gen
   import isa_cycle_pkg::*;
#(
   parameter int HI_W = 4
) (
   input  isa_state_e      state,
   input  isa_kind_t       kind_q,
   input  logic [HI_W-1:0] addr_hi,
   input  logic            addr_odd,
   output logic            memr_n,
   output logic            memw_n,
   output logic            ior_n,
   output logic            iow_n,
   output logic            smemr_n,
   output logic            smemw_n,
   output logic            ref_n,
   output logic            bhe_n,
   output logic            ale_cyc
);

   logic in_cyc, cmd_on, refr, low_meg;
   logic rd_mem, wr_mem, rd_io, wr_io;

   always_comb begin
      in_cyc  = (state != ST_IDLE);
      cmd_on  = (state == ST_CMD);
      refr    = (kind_q.src == SRC_REFRESH);
      low_meg = (addr_hi == '0);
      rd_mem  = cmd_on && (refr || (!kind_q.io && !kind_q.write));
      wr_mem  = cmd_on && !refr && !kind_q.io && kind_q.write;
      rd_io   = cmd_on && !refr && kind_q.io && !kind_q.write;
      wr_io   = cmd_on && !refr && kind_q.io && kind_q.write;
      memr_n  = !rd_mem;
      memw_n  = !wr_mem;
      ior_n   = !rd_io;
      iow_n   = !wr_io;
      smemr_n = !(rd_mem && (low_meg || refr));
      smemw_n = !(wr_mem && low_meg);
      ref_n   = !(in_cyc && refr);
      bhe_n   = !(in_cyc && !refr && (kind_q.wide || addr_odd));
      ale_cyc = (state == ST_ADDR) || (in_cyc && kind_q.src != SRC_HOST);
   end

endmodule

// File: rtl/isa_ext_ready.sv
module isa_ext_ready #(
   parameter int EXT_WAIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_master,
   input  logic ext_hit,
   input  logic ext_cmd,
   output logic iochrdy_out,
   output logic iochrdy_oe
);

   localparam int CW = $clog2(EXT_WAIT + 1);

   if (EXT_WAIT < 1) begin : g_bad_wait
      $error("isa_ext_ready: EXT_WAIT must be at least 1");
   end

   logic [CW-1:0] cnt;
   logic          cmd_prev;
   logic          start;

   assign start = ext_master && ext_hit && ext_cmd && !cmd_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         cmd_prev <= 1'b0;
      end else begin
         cmd_prev <= ext_cmd;
         if (!ext_master)    cnt <= '0;
         else if (start)     cnt <= CW'(EXT_WAIT);
         else if (cnt != '0) cnt <= cnt - 1'b1;
      end
   end

   assign iochrdy_out = (cnt == '0);
   assign iochrdy_oe  = ext_master && ext_hit;

   // R10: a new external command to an internal target pulls ready low next cycle
   a_r10_ready_low_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !iochrdy_out);

endmodule

// File: rtl/isa_nmi_latch.sv
module isa_nmi_latch #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic iochck_n,
   input  logic nmi_en,
   input  logic nmi_clr,
   output logic nmi_req
);

   logic chk_act;

   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("isa_nmi_latch: SYNC_STAGES must not be negative");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign chk_act = !iochck_n;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh <= '0;
         end else begin
            sh[0] <= !iochck_n;
            for (int i = 1; i < SYNC_STAGES; i++) sh[i] <= sh[i-1];
         end
      end
      assign chk_act = sh[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  nmi_req <= 1'b0;
      else if (chk_act && nmi_en)  nmi_req <= 1'b1;
      else if (nmi_clr)            nmi_req <= 1'b0;
   end

   // R11: the request stays set until a clear strobe
   a_r11_nmi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_req && !nmi_clr) |=> nmi_req);

endmodule

// File: rtl/isa_cycle_gen.sv
module isa_cycle_gen
   import isa_cycle_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int SA_W        = 20,
   parameter int LA_LO       = 17,
   parameter int MEG_BITS    = 20,
   parameter int MIN_CMD     = 3,
   parameter int EXT_WAIT    = 4,
   parameter int NMI_SYNC    = 0,
   localparam int LA_W       = ADDR_W - LA_LO,
   localparam int HI_W       = ADDR_W - MEG_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_io,
   input  logic              req_wide,
   input  logic [1:0]        req_src,
   input  logic              ext_master,
   input  logic              dma_owner,
   input  logic              ext_hit,
   input  logic              ext_cmd,
   input  logic              iochrdy_in,
   input  logic              mcs16_n_in,
   input  logic              iochck_n_in,
   input  logic              nmi_en,
   input  logic              nmi_clr,
   output logic [LA_W-1:0]   la_out,
   output logic              la_oe,
   output logic [SA_W-1:0]   sa_out,
   output logic              sa_oe,
   output logic              bhe_n,
   output logic              ale,
   output logic              aen,
   output logic              memr_n,
   output logic              memw_n,
   output logic              smemr_n,
   output logic              smemw_n,
   output logic              ior_n,
   output logic              iow_n,
   output logic              ref_n,
   output logic              cmd_oe,
   output logic              iochrdy_out,
   output logic              iochrdy_oe,
   output logic              busy,
   output logic              done,
   output logic              done_wide,
   output logic              nmi_req
);

   if (SA_W >= ADDR_W || LA_LO > SA_W || LA_LO < 1) begin : g_bad_lanes
      $error("isa_cycle_gen: address lane split is inconsistent");
   end
   if (MEG_BITS >= ADDR_W || MEG_BITS < 1) begin : g_bad_meg
      $error("isa_cycle_gen: MEG_BITS must lie inside the address");
   end

   isa_kind_t         req_kind;
   isa_state_e        state;
   logic [ADDR_W-1:0] addr_q;
   isa_kind_t         kind_q;
   logic              ale_cyc;

   always_comb begin
      req_kind.write = req_write;
      req_kind.io    = req_io;
      req_kind.wide  = req_wide;
      case (req_src)
         2'd1:    req_kind.src = SRC_DMA;
         2'd2:    req_kind.src = SRC_REFRESH;
         default: req_kind.src = SRC_HOST;
      endcase
   end

   isa_cycle_fsm #(.ADDR_W(ADDR_W), .MIN_CMD(MIN_CMD)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .req_kind   (req_kind),
      .ext_master (ext_master),
      .iochrdy_in (iochrdy_in),
      .mcs16_n_in (mcs16_n_in),
      .state      (state),
      .addr_q     (addr_q),
      .kind_q     (kind_q),
      .done_wide  (done_wide)
   );

   isa_strobe_gen #(.HI_W(HI_W)) u_strobe (
      .state    (state),
      .kind_q   (kind_q),
      .addr_hi  (addr_q[ADDR_W-1:MEG_BITS]),
      .addr_odd (addr_q[0]),
      .memr_n   (memr_n),
      .memw_n   (memw_n),
      .ior_n    (ior_n),
      .iow_n    (iow_n),
      .smemr_n  (smemr_n),
      .smemw_n  (smemw_n),
      .ref_n    (ref_n),
      .bhe_n    (bhe_n),
      .ale_cyc  (ale_cyc)
   );

   isa_ext_ready #(.EXT_WAIT(EXT_WAIT)) u_ready (
      .clk         (clk),
      .rst_n       (rst_n),
      .ext_master  (ext_master),
      .ext_hit     (ext_hit),
      .ext_cmd     (ext_cmd),
      .iochrdy_out (iochrdy_out),
      .iochrdy_oe  (iochrdy_oe)
   );

   isa_nmi_latch #(.SYNC_STAGES(NMI_SYNC)) u_nmi (
      .clk      (clk),
      .rst_n    (rst_n),
      .iochck_n (iochck_n_in),
      .nmi_en   (nmi_en),
      .nmi_clr  (nmi_clr),
      .nmi_req  (nmi_req)
   );

   assign la_out = addr_q[ADDR_W-1:LA_LO];
   assign sa_out = addr_q[SA_W-1:0];
   assign la_oe  = !ext_master;
   assign sa_oe  = !ext_master;
   assign cmd_oe = !ext_master;
   assign aen    = dma_owner;
   assign ale    = ale_cyc || ext_master;
   assign busy   = (state != ST_IDLE);
   assign done   = (state == ST_END);

   // R2: an idle block never starts a cycle while an external master owns the bus
   a_r2_no_start_under_master: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_master && !busy) |=> !busy);

   // R2: completion is a single-cycle pulse
   a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5: the low-megabyte write strobe never appears above the line
   a_r5_smemw_low_meg: assert property (@(posedge clk) disable iff (!rst_n)
      !smemw_n |-> (addr_q[ADDR_W-1:MEG_BITS] == '0));

   // R6: address latch enable is low when idle with no external owner
   a_r6_ale_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !ext_master) |-> !ale);

   // R3: at most one command strobe at a time
   a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({!memr_n, !memw_n, !ior_n, !iow_n}));

endmodule

// File: tb/isa_cycle_gen_bench.sv
`timescale 1ns/1ps
module isa_cycle_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [23:0] req_addr = '0;
   logic        req_write = 1'b0, req_io = 1'b0, req_wide = 1'b0;
   logic [1:0]  req_src = 2'd0;
   logic        ext_master = 1'b0, dma_owner = 1'b0, ext_hit = 1'b0, ext_cmd = 1'b0;
   logic        iochrdy_in = 1'b1, mcs16_n_in = 1'b1, iochck_n_in = 1'b1;
   logic        nmi_en = 1'b0, nmi_clr = 1'b0;

   logic [6:0]  la_out;
   logic [19:0] sa_out;
   logic la_oe, sa_oe, bhe_n, ale, aen, memr_n, memw_n, smemr_n, smemw_n;
   logic ior_n, iow_n, ref_n, cmd_oe, iochrdy_out, iochrdy_oe;
   logic busy, done, done_wide, nmi_req;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   // behavioural reference state
   int          m_ph = 0;
   int          m_cnt = 0;
   logic [23:0] m_addr = '0;
   bit          m_wr = 0, m_io = 0, m_wide = 0, m_w16 = 0;
   int          m_src = 0;
   int          m_rcnt = 0;
   bit          m_cprev = 0;
   bit          m_nmi = 0;

   always #2 clk = ~clk;

   isa_cycle_gen u_isa_cycle_gen (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .req_io(req_io), .req_wide(req_wide), .req_src(req_src),
      .ext_master(ext_master), .dma_owner(dma_owner), .ext_hit(ext_hit), .ext_cmd(ext_cmd),
      .iochrdy_in(iochrdy_in), .mcs16_n_in(mcs16_n_in), .iochck_n_in(iochck_n_in),
      .nmi_en(nmi_en), .nmi_clr(nmi_clr),
      .la_out(la_out), .la_oe(la_oe), .sa_out(sa_out), .sa_oe(sa_oe), .bhe_n(bhe_n),
      .ale(ale), .aen(aen), .memr_n(memr_n), .memw_n(memw_n), .smemr_n(smemr_n),
      .smemw_n(smemw_n), .ior_n(ior_n), .iow_n(iow_n), .ref_n(ref_n), .cmd_oe(cmd_oe),
      .iochrdy_out(iochrdy_out), .iochrdy_oe(iochrdy_oe), .busy(busy), .done(done),
      .done_wide(done_wide), .nmi_req(nmi_req)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // advance the model over the clock edge just passed
   task automatic model_step();
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_addr = '0; m_wr = 0; m_io = 0; m_wide = 0;
         m_src = 0; m_w16 = 0; m_rcnt = 0; m_cprev = 0; m_nmi = 0;
         return;
      end
      case (m_ph)
         0: if (req_valid && !ext_master) begin
               m_addr = req_addr; m_wr = req_write; m_io = req_io; m_wide = req_wide;
               m_src = (req_src == 2'd1) ? 1 : (req_src == 2'd2) ? 2 : 0;
               m_ph = 1;
            end
         1: m_ph = 2;
         2: begin m_ph = 3; m_cnt = 0; end
         3: if (m_cnt == 2) begin
               if (iochrdy_in) begin
                  m_ph = 4;
                  m_w16 = !mcs16_n_in && !m_io && (m_src != 2);
               end
            end else m_cnt++;
         default: m_ph = 0;
      endcase
      if (!ext_master) m_rcnt = 0;
      else if (ext_hit && ext_cmd && !m_cprev) m_rcnt = 4;
      else if (m_rcnt > 0) m_rcnt--;
      m_cprev = ext_cmd;
      if (!iochck_n_in && nmi_en) m_nmi = 1;
      else if (nmi_clr) m_nmi = 0;
   endtask

   task automatic compare();
      bit in_cyc, cmd, refr, lowm;
      bit e_memr, e_memw, e_ior, e_iow;
      in_cyc = (m_ph != 0);
      cmd    = (m_ph == 3);
      refr   = (m_src == 2);
      lowm   = (m_addr[23:20] == 4'h0);
      e_memr = !(cmd && (refr || (!m_io && !m_wr)));
      e_memw = !(cmd && !refr && !m_io && m_wr);
      e_ior  = !(cmd && !refr && m_io && !m_wr);
      e_iow  = !(cmd && !refr && m_io && m_wr);
      chk(la_out == m_addr[23:17], "R12 la_out", 32'(la_out), 32'(m_addr[23:17]));
      chk(sa_out == m_addr[19:0], "R12 sa_out", 32'(sa_out), 32'(m_addr[19:0]));
      chk({la_oe, sa_oe, cmd_oe} == {3{!ext_master}}, "R1 output enables",
          32'({la_oe, sa_oe, cmd_oe}), 32'({3{!ext_master}}));
      chk(ale == ((m_ph == 1) || (in_cyc && m_src != 0) || ext_master), "R6 ale",
          32'(ale), 32'((m_ph == 1) || (in_cyc && m_src != 0) || ext_master));
      chk(aen == dma_owner, "R8 aen", 32'(aen), 32'(dma_owner));
      chk({memr_n, memw_n, ior_n, iow_n} == {e_memr, e_memw, e_ior, e_iow},
          "R3 strobes", 32'({memr_n, memw_n, ior_n, iow_n}),
          32'({e_memr, e_memw, e_ior, e_iow}));
      chk(ref_n == !(in_cyc && refr), "R3 ref_n", 32'(ref_n), 32'(!(in_cyc && refr)));
      chk(smemr_n == (e_memr || !(lowm || refr)), "R5 smemr_n", 32'(smemr_n),
          32'(e_memr || !(lowm || refr)));
      chk(smemw_n == (e_memw || !lowm), "R5 smemw_n", 32'(smemw_n), 32'(e_memw || !lowm));
      chk(bhe_n == !(in_cyc && !refr && (m_wide || m_addr[0])), "R7 bhe_n", 32'(bhe_n),
          32'(!(in_cyc && !refr && (m_wide || m_addr[0]))));
      chk({busy, done} == {in_cyc, m_ph == 4}, "R2 busy/done", 32'({busy, done}),
          32'({in_cyc, m_ph == 4}));
      chk(done_wide == (m_ph == 4 && m_w16), "R9 done_wide", 32'(done_wide),
          32'(m_ph == 4 && m_w16));
      chk(iochrdy_oe == (ext_master && ext_hit), "R10 iochrdy_oe", 32'(iochrdy_oe),
          32'(ext_master && ext_hit));
      chk(iochrdy_out == (m_rcnt == 0), "R10 iochrdy_out", 32'(iochrdy_out),
          32'(m_rcnt == 0));
      chk(nmi_req == m_nmi, "R11 nmi_req", 32'(nmi_req), 32'(m_nmi));
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      model_step();
      compare();
   endtask

   // one full cycle; waits = cycles of low ready once the third command cycle is reached
   task automatic run_cycle(input logic [23:0] a, input bit wr, input bit io, input bit wd,
                            input logic [1:0] src, input int waits, input bit m16);
      int waited = 0;
      int strobe_cycles = 0;
      req_addr = a; req_write = wr; req_io = io; req_wide = wd; req_src = src;
      mcs16_n_in = !m16;
      req_valid = 1'b1;
      tick();
      req_valid = 1'b0;
      for (int i = 0; i < 60 && m_ph != 0; i++) begin
         if (m_ph == 3 && m_cnt == 2 && waited < waits) begin
            iochrdy_in = 1'b0; waited++;
         end else iochrdy_in = 1'b1;
         tick();
         if (!(memr_n && memw_n && ior_n && iow_n)) strobe_cycles++;
      end
      iochrdy_in = 1'b1;
      mcs16_n_in = 1'b1;
      chk(strobe_cycles == 3 + waits, "R4 command length", 32'(strobe_cycles), 32'(3 + waits));
   endtask

   initial begin
      repeat (3) tick();
      chk(!ale && !busy && la_out == 7'h0, "R6 reset state ale/busy/addr",
          32'({ale, busy, la_out}), 32'h0);
      rst_n = 1'b1;
      tick();

      run_cycle(24'h0A1234, 0, 0, 0, 2'd0, 0, 0);   // low memory read, even, narrow
      run_cycle(24'h1F0002, 1, 0, 1, 2'd0, 0, 0);   // memory write above 1 MByte, wide
      run_cycle(24'h000301, 0, 1, 0, 2'd0, 0, 1);   // odd IO read, select ignored
      chk(done_wide == 1'b0, "R9 select ignored in IO", 32'(done_wide), 32'h0);
      run_cycle(24'h000300, 1, 1, 0, 2'd3, 0, 0);   // IO write, source 3 as host
      run_cycle(24'h0C0010, 1, 0, 0, 2'd0, 3, 0);   // low memory write with 3 waits
      run_cycle(24'hF00000, 0, 0, 0, 2'd0, 1, 1);   // high memory read, 16-bit target
      run_cycle(24'hE12345, 1, 1, 1, 2'd2, 0, 1);   // refresh at high address
      dma_owner = 1'b1;
      run_cycle(24'h023456, 0, 0, 1, 2'd1, 2, 0);   // DMA read
      dma_owner = 1'b0;
      tick();

      // a request while busy is dropped
      req_addr = 24'h000111; req_src = 2'd0; req_write = 0; req_io = 0; req_wide = 0;
      req_valid = 1'b1; tick(); req_valid = 1'b0;
      tick();
      req_addr = 24'h0FFFFF; req_valid = 1'b1; tick(); req_valid = 1'b0;
      chk(sa_out == 20'h00111, "R2 request ignored while busy", 32'(sa_out), 32'h00111);
      for (int i = 0; i < 10 && m_ph != 0; i++) tick();

      // external master owns the bus
      ext_master = 1'b1; ext_hit = 1'b1;
      tick();
      req_addr = 24'h055555; req_valid = 1'b1; tick(); req_valid = 1'b0;
      tick();
      chk(!busy, "R2 request ignored under external master", 32'(busy), 32'h0);
      chk(sa_out == 20'h00111, "R12 address kept under external master", 32'(sa_out),
          32'h00111);
      ext_cmd = 1'b1;
      repeat (6) tick();
      ext_cmd = 1'b0; tick();
      ext_cmd = 1'b1; tick();
      ext_master = 1'b0;                           // countdown clears on release
      tick();
      chk(iochrdy_out == 1'b1, "R10 countdown cleared on release", 32'(iochrdy_out), 32'h1);
      ext_cmd = 1'b0; ext_hit = 1'b0;
      tick();

      // NMI latch
      iochck_n_in = 1'b0; nmi_en = 1'b0; tick();
      iochck_n_in = 1'b1; tick();
      chk(!nmi_req, "R11 disabled check ignored", 32'(nmi_req), 32'h0);
      nmi_en = 1'b1; iochck_n_in = 1'b0; tick();
      iochck_n_in = 1'b1; repeat (3) tick();
      chk(nmi_req, "R11 short pulse held", 32'(nmi_req), 32'h1);
      iochck_n_in = 1'b0; nmi_clr = 1'b1; tick();
      chk(nmi_req, "R11 set wins over clear", 32'(nmi_req), 32'h1);
      iochck_n_in = 1'b1; tick();
      nmi_clr = 1'b0; tick();
      chk(!nmi_req, "R11 cleared", 32'(nmi_req), 32'h0);

      run_cycle(24'h000003, 1, 0, 0, 2'd0, 0, 1);   // odd low write after all that
      repeat (2) tick();

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule